// File: doc/BRIEF.md
# Address Table Port Flush Sequencer

This block clears an Ethernet switch's learned-address table, one port at a time, without software involvement. After a single-cycle start request it drives an external address-table engine through its command interface. For each port it resets the engine's search cursor and selects that port as the owner filter. It then searches for the next address owned by that port. Each address found is handed back to the engine and erased, and the search repeats until the engine reports that no address is left.

The engine interface is a command strobe with a command code, an access code, a port map, a filter identifier and a 48-bit address split into a low word and a high word. The engine answers with a busy flag, a result code and the 48-bit address it found, split into two status words. The block waits for the engine to go idle before every command. It also waits for the engine to finish after every command before it reads the result. A watchdog bounds each of these waits. The run ends with a one-cycle done pulse, or with a one-cycle error pulse if the engine reports a command error or stays busy too long.

Top module: `mac_flush_seq`

## Requirements
- R1: A command strobe (`cmd_go`) is only issued when `eng_busy` was low in the previous cycle. The engine must raise `eng_busy` in the cycle after a strobe and keep it high for at least one cycle. The result and status words are read in the first cycle in which `eng_busy` is low again.
- R2: Ports are flushed in ascending order 0, 1, 2. Each port starts with a cursor reset: command code 3, access code 0. After that reset completes, `port_map` holds only the bit of that port (bit n for port n). `port_map` is 0 after reset and is never more than one-hot.
- R3: A search is command code 2 with access code 9. It is issued with `port_map` selecting the current port.
- R4: A search result of 0x101 aborts the whole run. `err` pulses for one cycle, no further strobe is issued, and `done` does not pulse.
- R5: A search result of 0 means an address was found. It is followed by an erase: command code 1, access code 15, the same `port_map`, and `fid` equal to 0.
- R6: Status word 0 carries address bytes 5, 4, 3 and 2 in bits 7:0, 15:8, 23:16 and 31:24. Status word 1 carries byte 1 in bits 7:0 and byte 0 in bits 15:8. The erase presents each byte at the same bit position of `ctl_addr_lo` and `ctl_addr_hi`.
- R7: After an erase completes, the next command is a new search for the same port.
- R8: Any non-zero search result other than 0x101 ends the current port. After port 2 ends this way, `done` pulses for exactly one cycle and the block returns to idle.
- R9: A wait, before or after a command, that sees `eng_busy` high for WD_LIMIT consecutive cycles raises `err` for one cycle and returns the block to idle. WD_LIMIT-1 cycles of busy do not trigger the error. If busy falls in the cycle in which the limit would be reached, the command completes normally.
- R10: After reset, `cmd_go`, `done`, `err` and `port_map` are low. A `start` pulse while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to begin a flush run |
| eng_busy | input | 1 | Engine busy flag |
| eng_result | input | RES_W (9) | Engine result code, valid when not busy |
| st_addr_lo | input | 32 | Found address, bytes 2 to 5 |
| st_addr_hi | input | 16 | Found address, bytes 0 and 1 |
| cmd_go | output | 1 | One-cycle command strobe |
| cmd_code | output | 4 | Command code |
| acc_code | output | 4 | Access code |
| port_map | output | NPORTS (3) | One-hot owner filter |
| fid | output | FID_W (4) | Filter identifier, always 0 |
| ctl_addr_lo | output | 32 | Address for erase, bytes 2 to 5 |
| ctl_addr_hi | output | 16 | Address for erase, bytes 0 and 1 |
| done | output | 1 | One-cycle pulse at successful end |
| err | output | 1 | One-cycle pulse at abort |

## Verification
Two functions can fall in the same cycle: the watchdog reaching its limit and the engine dropping busy to complete a command. The bench provokes this by having the engine model hold busy for exactly WD_LIMIT-1 cycles, which must complete normally, and for exactly WD_LIMIT cycles, which must raise the error after one command. A busy flag held high before the start shows that the pre-command wait is bounded in the same way. The bench also sweeps 64 table populations at three busy lengths. In every sweep run the table must end empty, each erase must hit the exact entry that was found, and the numbers of searches and erases must match counts computed from the population.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ISSUE, S_WAIT} fsm_t;
  typedef enum logic [1:0] {STEP_CUR, STEP_SEARCH, STEP_ERASE} step_t;

  localparam logic [3:0] CMD_CURSOR = 4'd3;
  localparam logic [3:0] ACC_CURSOR = 4'd0;
  localparam logic [3:0] CMD_SEARCH = 4'd2;
  localparam logic [3:0] ACC_SEARCH = 4'd9;
  localparam logic [3:0] CMD_ERASE  = 4'd1;
  localparam logic [3:0] ACC_ERASE  = 4'd15;

  function automatic logic [3:0] step_cmd(step_t s);
    case (s)
      STEP_CUR:    return CMD_CURSOR;
      STEP_SEARCH: return CMD_SEARCH;
      default:     return CMD_ERASE;
    endcase
  endfunction

  function automatic logic [3:0] step_acc(step_t s);
    case (s)
      STEP_CUR:    return ACC_CURSOR;
      STEP_SEARCH: return ACC_SEARCH;
      default:     return ACC_ERASE;
    endcase
  endfunction

  // mac[47:40] is byte 0 ... mac[7:0] is byte 5
  function automatic logic [47:0] mac_from_status(logic [31:0] lo, logic [15:0] hi);
    logic [7:0] b [6];
    b[5] = lo[7:0];   b[4] = lo[15:8];
    b[3] = lo[23:16]; b[2] = lo[31:24];
    b[1] = hi[7:0];   b[0] = hi[15:8];
    return {b[0], b[1], b[2], b[3], b[4], b[5]};
  endfunction

  function automatic logic [31:0] ctl_lo_of(logic [47:0] mac);
    return {mac[31:24], mac[23:16], mac[15:8], mac[7:0]};
  endfunction

  function automatic logic [15:0] ctl_hi_of(logic [47:0] mac);
    return {mac[47:40], mac[39:32]};
  endfunction

endpackage

// File: rtl/flush_wdog.sv
module flush_wdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (run)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/flush_addr_hold.sv
module flush_addr_hold (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] st_lo,
  input  logic [15:0] st_hi,
  output logic [31:0] ctl_lo,
  output logic [15:0] ctl_hi
);
  import flush_pkg::*;

  logic [47:0] mac_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mac_q <= '0;
    else if (load) mac_q <= mac_from_status(st_lo, st_hi);
  end

  assign ctl_lo = ctl_lo_of(mac_q);
  assign ctl_hi = ctl_hi_of(mac_q);
endmodule

// File: rtl/mac_flush_seq.sv
module mac_flush_seq #(
  parameter int NPORTS   = 3,
  parameter int WD_LIMIT = 1024,
  parameter int RES_W    = 9,
  parameter int FID_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              eng_busy,
  input  logic [RES_W-1:0]  eng_result,
  input  logic [31:0]       st_addr_lo,
  input  logic [15:0]       st_addr_hi,
  output logic              cmd_go,
  output logic [3:0]        cmd_code,
  output logic [3:0]        acc_code,
  output logic [NPORTS-1:0] port_map,
  output logic [FID_W-1:0]  fid,
  output logic [31:0]       ctl_addr_lo,
  output logic [15:0]       ctl_addr_hi,
  output logic              done,
  output logic              err
);
  import flush_pkg::*;

  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NPORTS - 1);
  localparam logic [RES_W-1:0]  RES_CMD_ERR = RES_W'(9'h101);

  fsm_t              state_q;
  step_t             step_q;
  logic [PIDX_W-1:0] port_q;
  logic              done_q, err_q;

  // named internal events
  logic in_wait, wait_done, pre_ready, wd_expire, wd_clear;
  logic found_evt, cmd_err_evt, port_end_evt, last_port;

  assign in_wait      = (state_q == S_PRE) || (state_q == S_WAIT);
  assign pre_ready    = (state_q == S_PRE)  && !eng_busy;
  assign wait_done    = (state_q == S_WAIT) && !eng_busy;
  assign found_evt    = wait_done && (step_q == STEP_SEARCH) && (eng_result == '0);
  assign cmd_err_evt  = wait_done && (step_q == STEP_SEARCH) && (eng_result == RES_CMD_ERR);
  assign port_end_evt = wait_done && (step_q == STEP_SEARCH) && !found_evt && !cmd_err_evt;
  assign last_port    = (port_q == LAST_PORT);
  assign wd_clear     = !in_wait || pre_ready || wait_done;

  flush_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (wd_clear),
    .run    (in_wait && eng_busy),
    .expire (wd_expire)
  );

  flush_addr_hold u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (found_evt),
    .st_lo  (st_addr_lo),
    .st_hi  (st_addr_hi),
    .ctl_lo (ctl_addr_lo),
    .ctl_hi (ctl_addr_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      step_q   <= STEP_CUR;
      port_q   <= '0;
      port_map <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          state_q  <= S_PRE;
          step_q   <= STEP_CUR;
          port_q   <= '0;
          port_map <= '0;
        end
        S_PRE: begin
          if (!eng_busy)      state_q <= S_ISSUE;
          else if (wd_expire) begin
            state_q <= S_IDLE;
            err_q   <= 1'b1;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (wd_expire) begin
            state_q <= S_IDLE;
            err_q   <= 1'b1;
          end else if (wait_done) begin
            state_q <= S_PRE;
            case (step_q)
              STEP_CUR: begin
                port_map <= NPORTS'(1) << port_q;
                step_q   <= STEP_SEARCH;
              end
              STEP_ERASE: step_q <= STEP_SEARCH;
              default: begin
                if (cmd_err_evt) begin
                  state_q <= S_IDLE;
                  err_q   <= 1'b1;
                end else if (found_evt) begin
                  step_q <= STEP_ERASE;
                end else if (last_port) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
                end else begin
                  port_q <= port_q + 1'b1;
                  step_q <= STEP_CUR;
                end
              end
            endcase
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_go   = (state_q == S_ISSUE);
  assign cmd_code = step_cmd(step_q);
  assign acc_code = step_acc(step_q);
  assign fid      = '0;
  assign done     = done_q;
  assign err      = err_q;

endmodule

// File: rtl/mac_flush_seq_chk.sv
module mac_flush_seq_chk #(
  parameter int NPORTS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_busy,
  input logic              cmd_go,
  input logic [3:0]        cmd_code,
  input logic [3:0]        acc_code,
  input logic [NPORTS-1:0] port_map,
  input logic              done,
  input logic              err
);
  // R1: strobe only after an idle engine cycle
  a_r1_cmd_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> $past(!eng_busy));

  // R1: strobes are separated by at least one wait cycle
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);

  // R2: port map never more than one-hot
  a_r2_map_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_map));

  // R3: search always carries a selected port
  a_r3_search_has_port: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_code == 4'd2) |-> (acc_code == 4'd9 && $onehot(port_map)));

  // R5: erase keeps the port filter of the search
  a_r5_erase_has_port: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_code == 4'd1) |-> (acc_code == 4'd15 && $onehot(port_map)));

  // R4: error and done never together
  a_r4_no_done_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mac_flush_seq mac_flush_seq_chk #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eng_busy (eng_busy),
  .cmd_go   (cmd_go),
  .cmd_code (cmd_code),
  .acc_code (acc_code),
  .port_map (port_map),
  .done     (done),
  .err      (err)
);

// File: tb/mac_flush_seq_test.sv
module mac_flush_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int WD = 8;
  localparam int NE = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic eng_busy;
  logic [8:0] eng_result;
  logic [31:0] st_lo;
  logic [15:0] st_hi;
  logic cmd_go, done, err;
  logic [3:0] cmd_code, acc_code;
  logic [NP-1:0] port_map;
  logic [3:0] fid;
  logic [31:0] ctl_lo;
  logic [15:0] ctl_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_flush_seq #(.NPORTS(NP), .WD_LIMIT(WD), .RES_W(9), .FID_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .eng_busy(eng_busy),
    .eng_result(eng_result), .st_addr_lo(st_lo), .st_addr_hi(st_hi),
    .cmd_go(cmd_go), .cmd_code(cmd_code), .acc_code(acc_code),
    .port_map(port_map), .fid(fid), .ctl_addr_lo(ctl_lo), .ctl_addr_hi(ctl_hi),
    .done(done), .err(err));

  // ---------------- engine model ----------------
  logic [47:0] tbl_mac [NE];
  int          tbl_own [NE];
  logic        tbl_vld [NE];
  int bsy_len = 1, err_at = 0;
  logic force_busy = 1'b0;
  logic busy_r = 1'b0;
  int cnt = 0, cursor = 0;
  logic [3:0] l_cmd, l_acc;
  logic [NP-1:0] l_map;
  logic [3:0] l_fid;
  logic [47:0] l_mac;
  int n_cmd = 0, n_search = 0, n_erase = 0, n_bad_erase = 0, n_order = 0, n_busy_viol = 0;
  int exp_port = -1, n_done = 0, n_err = 0;

  assign eng_busy = busy_r | force_busy;

  function automatic logic [31:0] st0_of(logic [47:0] m);
    // byte5 at 7:0, byte4 15:8, byte3 23:16, byte2 31:24
    logic [7:0] b5 = m[7:0], b4 = m[15:8], b3 = m[23:16], b2 = m[31:24];
    return {b2, b3, b4, b5};
  endfunction
  function automatic logic [15:0] st1_of(logic [47:0] m);
    logic [7:0] b1 = m[39:32], b0 = m[47:40];
    return {b0, b1};
  endfunction

  always @(posedge clk) begin
    if (done) n_done <= n_done + 1;
    if (err)  n_err  <= n_err + 1;
    if (cmd_go) begin
      n_cmd <= n_cmd + 1;
      if (eng_busy) n_busy_viol <= n_busy_viol + 1;
      l_cmd <= cmd_code; l_acc <= acc_code; l_map <= port_map; l_fid <= fid;
      l_mac <= {ctl_hi[15:8], ctl_hi[7:0], ctl_lo[31:24], ctl_lo[23:16], ctl_lo[15:8], ctl_lo[7:0]};
      busy_r <= 1'b1;
      cnt <= bsy_len;
    end else if (busy_r) begin
      if (cnt == 1) begin
        busy_r <= 1'b0;
        if (l_cmd == 4'd3 && l_acc == 4'd0) begin
          cursor <= 0;
          exp_port <= exp_port + 1;
        end else if (l_cmd == 4'd2 && l_acc == 4'd9) begin
          automatic int hit = -1;
          n_search <= n_search + 1;
          if (l_map != NP'(1 << exp_port)) n_order <= n_order + 1;
          for (int e = NE - 1; e >= cursor; e--)
            if (tbl_vld[e] && l_map[tbl_own[e]]) hit = e;
          if (n_search + 1 == err_at) eng_result <= 9'h101;
          else if (hit >= 0) begin
            eng_result <= 9'h000;
            st_lo <= st0_of(tbl_mac[hit]);
            st_hi <= st1_of(tbl_mac[hit]);
            cursor <= hit + 1;
          end else eng_result <= 9'h102;
        end else if (l_cmd == 4'd1 && l_acc == 4'd15) begin
          automatic int hit = -1;
          n_erase <= n_erase + 1;
          for (int e = 0; e < NE; e++)
            if (tbl_vld[e] && tbl_mac[e] == l_mac && l_map[tbl_own[e]] && l_fid == 4'd0) hit = e;
          if (hit >= 0) tbl_vld[hit] <= 1'b0;
          else n_bad_erase <= n_bad_erase + 1;
        end
      end else cnt <= cnt - 1;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0, fails = 0, cycles = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic clear_counts();
    n_cmd = 0; n_search = 0; n_erase = 0; n_bad_erase = 0; n_order = 0;
    n_busy_viol = 0; exp_port = -1; n_done = 0; n_err = 0;
  endtask

  task automatic fill(input int pat);
    for (int e = 0; e < NE; e++) begin
      tbl_vld[e] = pat[e];
      tbl_own[e] = (pat + e) % NP;
      tbl_mac[e] = {8'h02, 8'(e), 8'(pat), 8'h5A ^ 8'(e), 8'hC3, 8'(e * 17 + pat)};
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (n_done != 0 || n_err != 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int remaining();
    int r = 0;
    for (int e = 0; e < NE; e++) if (tbl_vld[e]) r++;
    return r;
  endfunction

  initial begin
    int total, c_at;
    eng_result = '0; st_lo = '0; st_hi = '0;
    fill(0);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(cmd_go == 0 && done == 0 && err == 0, "R10 reset outputs", int'(cmd_go | done | err), 0);
    chk(port_map == 0, "R10 reset port_map", int'(port_map), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6 R7 R8: sweep populations and busy lengths
    for (int pat = 0; pat < 64; pat++) begin
      fill(pat);
      total = $countones(pat[NE-1:0]);
      bsy_len = 1 + pat % 3;
      clear_counts();
      pulse_start();
      wait_end(2000);
      chk(n_done == 1 && n_err == 0, "R8 done once", n_done * 10 + n_err, 10);
      chk(remaining() == 0, "R5 table empty", remaining(), 0);
      chk(n_bad_erase == 0, "R6 erase address match", n_bad_erase, 0);
      chk(n_erase == total, "R5 erase count", n_erase, total);
      chk(n_search == total + NP, "R7 search count", n_search, total + NP);
      chk(n_order == 0 && exp_port == NP - 1, "R2 port order", n_order, 0);
      chk(n_busy_viol == 0, "R1 busy before command", n_busy_viol, 0);
    end

    // R10: start while running is ignored
    fill(63); bsy_len = 2; clear_counts();
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_end(2000);
    chk(n_search == NE + NP, "R10 restart ignored", n_search, NE + NP);
    chk(n_done == 1, "R10 single done", n_done, 1);

    // R4: command error on second search
    fill(63); bsy_len = 1; err_at = 2; clear_counts();
    pulse_start();
    wait_end(2000);
    c_at = n_cmd;
    chk(n_err == 1 && n_done == 0, "R4 abort", n_err * 10 + n_done, 10);
    repeat (30) @(negedge clk);
    chk(n_cmd == c_at, "R4 no command after abort", n_cmd, c_at);
    chk(remaining() == NE - 1, "R4 one erase before abort", remaining(), NE - 1);
    err_at = 0;

    // R9: busy for WD-1 cycles completes
    fill(7); bsy_len = WD - 1; clear_counts();
    pulse_start();
    wait_end(4000);
    chk(n_done == 1 && n_err == 0, "R9 limit-1 completes", n_done * 10 + n_err, 10);

    // R9: busy for WD cycles expires after the first command
    fill(7); bsy_len = WD; clear_counts();
    pulse_start();
    wait_end(4000);
    chk(n_err == 1 && n_done == 0, "R9 limit expires", n_err * 10 + n_done, 10);
    chk(n_cmd == 1, "R9 one command before expiry", n_cmd, 1);
    repeat (WD + 2) @(negedge clk);

    // R9: stuck busy before any command
    fill(7); bsy_len = 1; clear_counts(); force_busy = 1'b1;
    pulse_start();
    wait_end(200);
    chk(n_err == 1 && n_cmd == 0, "R9 pre-wait bounded", n_err * 10 + n_cmd, 10);
    force_busy = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule